// File: doc/BRIEF.md
# Bank Address Translator with Work RAM Gate

This block turns CPU and PPU bus addresses into physical addresses for program ROM, character memory and work RAM. It also turns them into a nametable page choice. Four 5-bit control words set the translation. They are loaded elsewhere, and this block only decodes them. Board straps give the program ROM size, the character ROM size and whether character memory is RAM. Two more straps give the work RAM size and whether the work RAM enable bit is obeyed.

Every output is registered. A change on any input shows at the outputs after exactly one clock edge. The program side offers three 16 KB banking arrangements. The top bit of control word 1 adds a 256 KB outer offset to every program bank number, including the fixed banks. The character side offers either two independent 4 KB banks or one 8 KB bank. The work RAM window at 0x6000-0x7FFF can be gated off; in that state a read is flagged as open bus. A 16 KB work RAM has its page chosen by a bit of control word 1.

Top module: `bank_xlate`

## Requirements
- R1: `mirror_o` equals control word 0 bits 1:0 (0 single lower, 1 single upper, 2 vertical, 3 horizontal). `nt_page_o` is 0 for code 0, 1 for code 1, PPU address bit 10 for code 2 and PPU address bit 11 for code 3.
- R2: With control word 0 bits 3:2 = 11, the CPU window 0x8000-0xBFFF uses bank number control word 3 bits 3:0, and 0xC000-0xFFFF uses bank 15. `prg_addr_o` = {bank, cpu_addr[13:0]}.
- R3: With control word 0 bits 3:2 = 10, window 0x8000 uses bank 0 and window 0xC000 uses control word 3 bits 3:0.
- R4: With control word 0 bit 3 = 0, the 32 KB at 0x8000 uses bank {ctl3[3:1], cpu_addr[14]}, so control word 3 bit 0 has no effect.
- R5: Control word 1 bit 4 adds 16 to every program bank number, the fixed banks 0 and 15 included.
- R6: The program bank number is ANDed with 2^`prg_size_i`-1 before it forms the address. `prg_size_i` is log2 of the count of 16 KB banks.
- R7: With control word 0 bit 4 = 1, PPU addresses 0x0000-0x0FFF use 4 KB bank control word 1 and 0x1000-0x1FFF use control word 2. `chr_addr_o` = {bank, ppu_addr[11:0]}.
- R8: With control word 0 bit 4 = 0, one 8 KB bank is used, with 4 KB bank number {ctl1[4:1], ppu_addr[12]}.
- R9: The character bank number is ANDed with 2^`chr_size_i`-1. `chr_size_i` is log2 of the count of 4 KB banks.
- R10: With `chr_ram_i` = 1 in 8 KB mode, `chr_addr_o` equals ppu_addr[12:0] zero-extended, with no banking.
- R11: For CPU accesses in 0x6000-0x7FFF, control word 3 bit 4 = 1 blocks `wram_wr_o` and `wram_rd_o` and raises `open_bus_o` on reads. `wram_force_i` = 1 keeps the RAM enabled regardless of that bit. Accesses outside the window assert none of the three outputs.
- R12: `wram_addr_o` = {page, cpu_addr[12:0]}. The page is 0 unless `wram_big_i` = 1. In that case the page is ctl1[4] in 4 KB character mode and ctl1[3] in 8 KB mode.
- R13: All outputs are 0 while reset is held. After reset, each output reflects its inputs one clock edge after they are applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl0_i | input | 5 | Control word 0: mirroring, program mode, character mode |
| ctl1_i | input | 5 | Control word 1: low character bank, outer program bit, RAM page |
| ctl2_i | input | 5 | Control word 2: high character bank |
| ctl3_i | input | 5 | Control word 3: program bank, RAM disable |
| cpu_addr_i | input | 16 | CPU address |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| ppu_addr_i | input | 14 | PPU address |
| prg_size_i | input | 3 | log2 of the number of 16 KB program banks |
| chr_size_i | input | 3 | log2 of the number of 4 KB character banks |
| chr_ram_i | input | 1 | Character memory is RAM |
| wram_big_i | input | 1 | Work RAM is 16 KB |
| wram_force_i | input | 1 | Ignore the RAM disable bit |
| prg_addr_o | output | 19 | Program ROM address |
| chr_addr_o | output | 17 | Character memory address |
| mirror_o | output | 2 | Mirroring code |
| nt_page_o | output | 1 | Selected nametable page |
| wram_addr_o | output | 14 | Work RAM address |
| wram_rd_o | output | 1 | Work RAM read enable |
| wram_wr_o | output | 1 | Work RAM write enable |
| open_bus_o | output | 1 | Read in the RAM window while the RAM is disabled |

## Verification
Every output passes through one register stage. A bad decode of a control word shows as a wrong bank field on the very next edge after the triggering address is presented. The error stays hidden until that address is used: a fault in the fixed-bank path appears only at 0xC000 in one mode. A masking fault appears only when a bank number exceeds the strapped size. The stimulus therefore pairs each mode with addresses in both halves of each window, and with bank numbers above the strapped sizes. A gating fault shows as a write enable or an open-bus flag one cycle after the access.

// File: rtl/bx_pkg.sv
package bx_pkg;
    typedef enum logic [1:0] {
        MIR_ONE_LO = 2'd0,
        MIR_ONE_HI = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mir_e;

    typedef enum logic [1:0] {
        PM_PAIR_A  = 2'b00,
        PM_PAIR_B  = 2'b01,
        PM_FIX_LO  = 2'b10,
        PM_FIX_HI  = 2'b11
    } prg_mode_e;
endpackage

// File: rtl/bx_prg_map.sv
module bx_prg_map #(
    parameter int REG_W   = 5,
    parameter int WIN_AW  = 14,
    parameter int STRAP_W = 3,
    localparam int INNER_W = REG_W - 1,
    localparam int OUT_AW  = REG_W + WIN_AW
) (
    input  logic [1:0]         mode_i,
    input  logic               outer_i,
    input  logic [REG_W-1:0]   bank_i,
    input  logic               win_hi_i,
    input  logic [WIN_AW-1:0]  offset_i,
    input  logic [STRAP_W-1:0] size_i,
    output logic [OUT_AW-1:0]  addr_o
);
    import bx_pkg::*;

    logic [INNER_W-1:0] inner;
    logic [REG_W:0]     limit;
    logic [REG_W:0]     mask_full;
    logic [REG_W-1:0]   bank_full;

    always_comb begin
        unique case (prg_mode_e'(mode_i))
            PM_FIX_HI: inner = win_hi_i ? {INNER_W{1'b1}} : bank_i[INNER_W-1:0];
            PM_FIX_LO: inner = win_hi_i ? bank_i[INNER_W-1:0] : {INNER_W{1'b0}};
            default:   inner = {bank_i[INNER_W-1:1], win_hi_i};
        endcase
        limit     = (REG_W+1)'(1) << size_i;
        mask_full = limit - (REG_W+1)'(1);
        bank_full = {outer_i, inner} & mask_full[REG_W-1:0];
        addr_o    = {bank_full, offset_i};
    end
endmodule

// File: rtl/bx_chr_map.sv
module bx_chr_map #(
    parameter int REG_W   = 5,
    parameter int WIN_AW  = 12,
    parameter int STRAP_W = 3,
    localparam int OUT_AW = REG_W + WIN_AW
) (
    input  logic               split_i,
    input  logic [REG_W-1:0]   bank_lo_i,
    input  logic [REG_W-1:0]   bank_hi_i,
    input  logic               half_i,
    input  logic [WIN_AW-1:0]  offset_i,
    input  logic               is_ram_i,
    input  logic [STRAP_W-1:0] size_i,
    output logic [OUT_AW-1:0]  addr_o
);
    logic [REG_W-1:0] bank;
    logic [REG_W:0]   limit;
    logic [REG_W:0]   mask_full;

    always_comb begin
        if (split_i) begin
            bank = half_i ? bank_hi_i : bank_lo_i;
        end else begin
            bank = {bank_lo_i[REG_W-1:1], half_i};
        end
        limit     = (REG_W+1)'(1) << size_i;
        mask_full = limit - (REG_W+1)'(1);
        if (is_ram_i && !split_i) begin
            addr_o = OUT_AW'({half_i, offset_i});
        end else begin
            addr_o = {bank & mask_full[REG_W-1:0], offset_i};
        end
    end
endmodule

// File: rtl/bx_nt_map.sv
module bx_nt_map (
    input  logic [1:0] mode_i,
    input  logic       a10_i,
    input  logic       a11_i,
    output logic       page_o
);
    import bx_pkg::*;

    always_comb begin
        unique case (mir_e'(mode_i))
            MIR_ONE_LO: page_o = 1'b0;
            MIR_ONE_HI: page_o = 1'b1;
            MIR_VERT:   page_o = a10_i;
            default:    page_o = a11_i;
        endcase
    end
endmodule

// File: rtl/bx_wram_gate.sv
module bx_wram_gate #(
    parameter int CPU_AW  = 16,
    parameter int PAGE_AW = 13,
    localparam int OUT_AW = PAGE_AW + 1
) (
    input  logic [CPU_AW-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              off_bit_i,
    input  logic              force_i,
    input  logic              big_i,
    input  logic              split_i,
    input  logic              sel_split_i,
    input  logic              sel_whole_i,
    output logic [OUT_AW-1:0] addr_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              open_o
);
    localparam int TAG_W = CPU_AW - PAGE_AW;

    logic hit;
    logic live;
    logic page;

    always_comb begin
        hit    = (addr_i[CPU_AW-1:PAGE_AW] == TAG_W'(3));
        live   = force_i || !off_bit_i;
        page   = big_i && (split_i ? sel_split_i : sel_whole_i);
        addr_o = {page, addr_i[PAGE_AW-1:0]};
        rd_o   = hit && rd_i && live;
        wr_o   = hit && wr_i && live;
        open_o = hit && rd_i && !live;
    end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate #(
    parameter int REG_W      = 5,
    parameter int CPU_AW     = 16,
    parameter int PPU_AW     = 14,
    parameter int PRG_WIN_AW = 14,
    parameter int CHR_WIN_AW = 12,
    parameter int RAM_PG_AW  = 13,
    parameter int STRAP_W    = 3,
    localparam int PRG_AW    = REG_W + PRG_WIN_AW,
    localparam int CHR_AW    = REG_W + CHR_WIN_AW,
    localparam int RAM_AW    = RAM_PG_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   ctl0_i,
    input  logic [REG_W-1:0]   ctl1_i,
    input  logic [REG_W-1:0]   ctl2_i,
    input  logic [REG_W-1:0]   ctl3_i,
    input  logic [CPU_AW-1:0]  cpu_addr_i,
    input  logic               cpu_rd_i,
    input  logic               cpu_wr_i,
    input  logic [PPU_AW-1:0]  ppu_addr_i,
    input  logic [STRAP_W-1:0] prg_size_i,
    input  logic [STRAP_W-1:0] chr_size_i,
    input  logic               chr_ram_i,
    input  logic               wram_big_i,
    input  logic               wram_force_i,
    output logic [PRG_AW-1:0]  prg_addr_o,
    output logic [CHR_AW-1:0]  chr_addr_o,
    output logic [1:0]         mirror_o,
    output logic               nt_page_o,
    output logic [RAM_AW-1:0]  wram_addr_o,
    output logic               wram_rd_o,
    output logic               wram_wr_o,
    output logic               open_bus_o
);
    import bx_pkg::*;

    typedef struct packed {
        logic [PRG_AW-1:0] prg;
        logic [CHR_AW-1:0] chr;
        mir_e              mir;
        logic              nt;
        logic [RAM_AW-1:0] ram;
        logic              rd;
        logic              wr;
        logic              open;
    } out_t;

    out_t out_d;
    out_t out_q;

    logic [PRG_AW-1:0] prg_w;
    logic [CHR_AW-1:0] chr_w;
    logic              nt_w;
    logic [RAM_AW-1:0] ram_w;
    logic              rd_w;
    logic              wr_w;
    logic              open_w;

    bx_prg_map #(
        .REG_W   (REG_W),
        .WIN_AW  (PRG_WIN_AW),
        .STRAP_W (STRAP_W)
    ) u_prg (
        .mode_i   (ctl0_i[3:2]),
        .outer_i  (ctl1_i[REG_W-1]),
        .bank_i   (ctl3_i),
        .win_hi_i (cpu_addr_i[PRG_WIN_AW]),
        .offset_i (cpu_addr_i[PRG_WIN_AW-1:0]),
        .size_i   (prg_size_i),
        .addr_o   (prg_w)
    );

    bx_chr_map #(
        .REG_W   (REG_W),
        .WIN_AW  (CHR_WIN_AW),
        .STRAP_W (STRAP_W)
    ) u_chr (
        .split_i   (ctl0_i[4]),
        .bank_lo_i (ctl1_i),
        .bank_hi_i (ctl2_i),
        .half_i    (ppu_addr_i[CHR_WIN_AW]),
        .offset_i  (ppu_addr_i[CHR_WIN_AW-1:0]),
        .is_ram_i  (chr_ram_i),
        .size_i    (chr_size_i),
        .addr_o    (chr_w)
    );

    bx_nt_map u_nt (
        .mode_i (ctl0_i[1:0]),
        .a10_i  (ppu_addr_i[10]),
        .a11_i  (ppu_addr_i[11]),
        .page_o (nt_w)
    );

    bx_wram_gate #(
        .CPU_AW  (CPU_AW),
        .PAGE_AW (RAM_PG_AW)
    ) u_ram (
        .addr_i      (cpu_addr_i),
        .rd_i        (cpu_rd_i),
        .wr_i        (cpu_wr_i),
        .off_bit_i   (ctl3_i[REG_W-1]),
        .force_i     (wram_force_i),
        .big_i       (wram_big_i),
        .split_i     (ctl0_i[4]),
        .sel_split_i (ctl1_i[4]),
        .sel_whole_i (ctl1_i[3]),
        .addr_o      (ram_w),
        .rd_o        (rd_w),
        .wr_o        (wr_w),
        .open_o      (open_w)
    );

    always_comb begin
        out_d      = out_q;
        out_d.prg  = prg_w;
        out_d.chr  = chr_w;
        out_d.mir  = mir_e'(ctl0_i[1:0]);
        out_d.nt   = nt_w;
        out_d.ram  = ram_w;
        out_d.rd   = rd_w;
        out_d.wr   = wr_w;
        out_d.open = open_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign prg_addr_o  = out_q.prg;
    assign chr_addr_o  = out_q.chr;
    assign mirror_o    = out_q.mir;
    assign nt_page_o   = out_q.nt;
    assign wram_addr_o = out_q.ram;
    assign wram_rd_o   = out_q.rd;
    assign wram_wr_o   = out_q.wr;
    assign open_bus_o  = out_q.open;
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
    parameter int REG_W   = 5,
    parameter int CPU_AW  = 16,
    parameter int PPU_AW  = 14,
    parameter int PRG_AW  = 19,
    parameter int CHR_AW  = 17,
    parameter int STRAP_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [REG_W-1:0]   ctl0_i,
    input logic [REG_W-1:0]   ctl1_i,
    input logic [REG_W-1:0]   ctl3_i,
    input logic [CPU_AW-1:0]  cpu_addr_i,
    input logic               cpu_rd_i,
    input logic               cpu_wr_i,
    input logic [PPU_AW-1:0]  ppu_addr_i,
    input logic [STRAP_W-1:0] prg_size_i,
    input logic               chr_ram_i,
    input logic               wram_force_i,
    input logic [PRG_AW-1:0]  prg_addr_o,
    input logic [CHR_AW-1:0]  chr_addr_o,
    input logic [1:0]         mirror_o,
    input logic               nt_page_o,
    input logic               wram_rd_o,
    input logic               wram_wr_o,
    input logic               open_bus_o
);
    localparam logic [REG_W-1:0] FIXED_HI = {1'b0, {(REG_W-1){1'b1}}};

    assert_mirror_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> mirror_o == $past(ctl0_i[1:0]));

    assert_vert_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0_i[1:0] == 2'b10) |=> nt_page_o == $past(ppu_addr_i[10]));

    assert_fixed_top_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_i[CPU_AW-1:CPU_AW-2] == 2'b11 && ctl0_i[3:2] == 2'b11
         && !ctl1_i[REG_W-1] && prg_size_i == STRAP_W'(REG_W))
        |=> prg_addr_o[PRG_AW-1 -: REG_W] == FIXED_HI);

    assert_prg_within_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (prg_addr_o[PRG_AW-1 -: REG_W] >> $past(prg_size_i)) == '0);

    assert_chr_ram_flat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_ram_i && !ctl0_i[4])
        |=> chr_addr_o == CHR_AW'($past(ppu_addr_i[12:0])));

    assert_no_write_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && ctl3_i[REG_W-1] && !wram_force_i) |=> !wram_wr_o);

    assert_read_when_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && cpu_addr_i[CPU_AW-1:13] == 3'b011 && !ctl3_i[REG_W-1])
        |=> (wram_rd_o && !open_bus_o));
endmodule

bind bank_xlate bx_checker #(
    .REG_W   (REG_W),
    .CPU_AW  (CPU_AW),
    .PPU_AW  (PPU_AW),
    .PRG_AW  (PRG_AW),
    .CHR_AW  (CHR_AW),
    .STRAP_W (STRAP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl0_i       (ctl0_i),
    .ctl1_i       (ctl1_i),
    .ctl3_i       (ctl3_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_rd_i     (cpu_rd_i),
    .cpu_wr_i     (cpu_wr_i),
    .ppu_addr_i   (ppu_addr_i),
    .prg_size_i   (prg_size_i),
    .chr_ram_i    (chr_ram_i),
    .wram_force_i (wram_force_i),
    .prg_addr_o   (prg_addr_o),
    .chr_addr_o   (chr_addr_o),
    .mirror_o     (mirror_o),
    .nt_page_o    (nt_page_o),
    .wram_rd_o    (wram_rd_o),
    .wram_wr_o    (wram_wr_o),
    .open_bus_o   (open_bus_o)
);

// File: tb/bank_xlate_tb.sv
module bank_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ctl0, ctl1, ctl2, ctl3;
    logic [15:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [13:0] ppu_addr;
    logic [2:0]  prg_size, chr_size;
    logic        chr_ram, wram_big, wram_force;
    logic [18:0] prg_addr;
    logic [16:0] chr_addr;
    logic [1:0]  mirror;
    logic        nt_page;
    logic [13:0] wram_addr;
    logic        wram_rd, wram_wr, open_bus;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bank_xlate u_dut (
        .clk (clk), .rst_n (rst_n),
        .ctl0_i (ctl0), .ctl1_i (ctl1), .ctl2_i (ctl2), .ctl3_i (ctl3),
        .cpu_addr_i (cpu_addr), .cpu_rd_i (cpu_rd), .cpu_wr_i (cpu_wr),
        .ppu_addr_i (ppu_addr), .prg_size_i (prg_size), .chr_size_i (chr_size),
        .chr_ram_i (chr_ram), .wram_big_i (wram_big), .wram_force_i (wram_force),
        .prg_addr_o (prg_addr), .chr_addr_o (chr_addr), .mirror_o (mirror),
        .nt_page_o (nt_page), .wram_addr_o (wram_addr), .wram_rd_o (wram_rd),
        .wram_wr_o (wram_wr), .open_bus_o (open_bus)
    );

    typedef struct packed {
        logic [4:0]  c0, c1, c2, c3;
        logic [15:0] ca;
        logic [13:0] pa;
        logic [18:0] prg;
        logic [16:0] chr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'h0C, 5'h00, 5'h00, 5'h05, 16'h8123, 14'h0000, 19'h14123, 17'h00000}, // R2 low window
        '{5'h0C, 5'h00, 5'h00, 5'h05, 16'hC456, 14'h1ABC, 19'h3C456, 17'h01ABC}, // R2 fixed 15, R8
        '{5'h0C, 5'h10, 5'h00, 5'h02, 16'hC001, 14'h0010, 19'h7C001, 17'h10010}, // R5 fixed 15+16
        '{5'h08, 5'h00, 5'h00, 5'h07, 16'h8FFF, 14'h0000, 19'h00FFF, 17'h00000}, // R3 fixed 0
        '{5'h08, 5'h00, 5'h00, 5'h07, 16'hE000, 14'h0FFF, 19'h1E000, 17'h00FFF}, // R3 switch high
        '{5'h08, 5'h10, 5'h00, 5'h07, 16'h8000, 14'h1000, 19'h40000, 17'h11000}, // R5 fixed 0+16
        '{5'h00, 5'h00, 5'h00, 5'h0B, 16'h8004, 14'h0000, 19'h28004, 17'h00000}, // R4 even
        '{5'h04, 5'h00, 5'h00, 5'h0B, 16'hC004, 14'h0000, 19'h2C004, 17'h00000}, // R4 odd
        '{5'h1C, 5'h03, 5'h1E, 5'h00, 16'h8000, 14'h0345, 19'h00000, 17'h03345}, // R7 low half
        '{5'h1C, 5'h03, 5'h1E, 5'h00, 16'hC000, 14'h1345, 19'h3C000, 17'h1E345}, // R7 high half
        '{5'h0C, 5'h07, 5'h00, 5'h00, 16'h8000, 14'h0001, 19'h00000, 17'h06001}, // R8 even half
        '{5'h0C, 5'h07, 5'h00, 5'h00, 16'h8000, 14'h1001, 19'h00000, 17'h07001}  // R8 odd half
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic set_ctl(input logic [4:0] a, b, c, d);
        ctl0 = a; ctl1 = b; ctl2 = c; ctl3 = d;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        set_ctl(5'h1F, 5'h1F, 5'h1F, 5'h0F);
        cpu_addr = 16'hC000; cpu_rd = 1'b1; cpu_wr = 1'b1; ppu_addr = 14'h1FFF;
        prg_size = 3'd5; chr_size = 3'd5; chr_ram = 1'b0;
        wram_big = 1'b0; wram_force = 1'b0;
        repeat (3) @(negedge clk);
        // R13: outputs held at zero during reset
        chk("R13 reset prg", 32'(prg_addr), 0);
        chk("R13 reset chr", 32'(chr_addr), 0);
        chk("R13 reset flags", 32'({wram_rd, wram_wr, open_bus, nt_page}), 0);
        rst_n = 1'b1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;

        for (int i = 0; i < NV; i++) begin
            set_ctl(VECS[i].c0, VECS[i].c1, VECS[i].c2, VECS[i].c3);
            cpu_addr = VECS[i].ca; ppu_addr = VECS[i].pa;
            @(negedge clk);
            chk($sformatf("R2-R8 vector %0d prg", i), 32'(prg_addr), 32'(VECS[i].prg));
            chk($sformatf("R2-R8 vector %0d chr", i), 32'(chr_addr), 32'(VECS[i].chr));
        end

        // R13: one edge of latency
        set_ctl(5'h0C, 5'h00, 5'h00, 5'h03); cpu_addr = 16'h8000;
        #1 chk("R13 before edge", 32'(prg_addr), 0);
        @(negedge clk);
        chk("R13 after edge", 32'(prg_addr), 32'h0C000);

        // R6: program mask with 4 banks
        prg_size = 3'd2; set_ctl(5'h0C, 5'h00, 5'h00, 5'h06); cpu_addr = 16'h8000;
        @(negedge clk); chk("R6 switch bank masked", 32'(prg_addr), 32'h08000);
        cpu_addr = 16'hC000;
        @(negedge clk); chk("R6 fixed bank masked", 32'(prg_addr), 32'h0C000);
        prg_size = 3'd5;

        // R9: character mask with 8 banks
        chr_size = 3'd3; set_ctl(5'h10, 5'h1D, 5'h00, 5'h00); ppu_addr = 14'h0010;
        @(negedge clk); chk("R9 chr masked", 32'(chr_addr), 32'h05010);
        chr_size = 3'd5;

        // R10: character RAM unbanked in 8 KB mode
        chr_ram = 1'b1; set_ctl(5'h00, 5'h1F, 5'h00, 5'h00); ppu_addr = 14'h1ABC;
        @(negedge clk); chk("R10 chr ram flat", 32'(chr_addr), 32'h01ABC);
        chr_ram = 1'b0;

        // R1: mirroring codes and nametable page
        ppu_addr = 14'h2400;
        for (int m = 0; m < 4; m++) begin
            ctl0 = 5'(m);
            @(negedge clk);
            chk("R1 mirror code", 32'(mirror), 32'(m));
            chk("R1 page a10 set", 32'(nt_page), (m == 1 || m == 2) ? 1 : 0);
        end
        ppu_addr = 14'h2800;
        ctl0 = 5'h02; @(negedge clk); chk("R1 vertical a11 set", 32'(nt_page), 0);
        ctl0 = 5'h03; @(negedge clk); chk("R1 horizontal a11 set", 32'(nt_page), 1);

        // R11: RAM gate
        set_ctl(5'h00, 5'h00, 5'h00, 5'h10); cpu_addr = 16'h6000; cpu_wr = 1'b1;
        @(negedge clk); chk("R11 write blocked", 32'(wram_wr), 0);
        cpu_wr = 1'b0; cpu_rd = 1'b1;
        @(negedge clk); chk("R11 open bus", 32'({wram_rd, open_bus}), 32'b01);
        wram_force = 1'b1; cpu_rd = 1'b0; cpu_wr = 1'b1;
        @(negedge clk); chk("R11 forced write", 32'(wram_wr), 1);
        cpu_wr = 1'b0; cpu_rd = 1'b1;
        @(negedge clk); chk("R11 forced read", 32'({wram_rd, open_bus}), 32'b10);
        wram_force = 1'b0; ctl3 = 5'h00;
        @(negedge clk); chk("R11 enabled read", 32'({wram_rd, open_bus}), 32'b10);
        cpu_addr = 16'h8000; cpu_rd = 1'b1; cpu_wr = 1'b1;
        @(negedge clk); chk("R11 outside window", 32'({wram_rd, wram_wr, open_bus}), 0);
        cpu_rd = 1'b0; cpu_wr = 1'b0;

        // R12: work RAM page choice
        cpu_addr = 16'h6123;
        wram_big = 1'b1; set_ctl(5'h10, 5'h10, 5'h00, 5'h00);
        @(negedge clk); chk("R12 split page", 32'(wram_addr), 32'h2123);
        set_ctl(5'h00, 5'h08, 5'h00, 5'h00);
        @(negedge clk); chk("R12 whole page", 32'(wram_addr), 32'h2123);
        set_ctl(5'h00, 5'h10, 5'h00, 5'h00);
        @(negedge clk); chk("R12 whole ignores bit4", 32'(wram_addr), 32'h0123);
        wram_big = 1'b0; set_ctl(5'h10, 5'h10, 5'h00, 5'h00);
        @(negedge clk); chk("R12 small ram page", 32'(wram_addr), 32'h0123);

        finish_run();
    end
endmodule